// File: doc/BRIEF.md
# Command/Data Byte Router with Character Segment Encoding

This block sits behind a serial byte receiver in a display controller. Each received byte arrives with a tag saying whether it is a command or data. The block latches one byte at a time and acknowledges it. On the next clock it routes the byte. Command bytes go to a command-decoder port. Data bytes go to a display-memory write port, either unchanged or converted into a segment pattern.

The block holds two mode bits, both loaded by the command decoder through a configuration strobe. The first is the multiplex ratio: divide-by-3 or divide-by-4. The second turns character encoding on or off. While encoding is on, bit 7 of a data byte picks the encoder. A 0 selects a 7-segment encoder driven by the low nibble. A 1 selects a 14-segment encoder driven by the low seven bits. The 14-segment encoder may be used only in divide-by-4 mode. If it is requested in divide-by-3 mode, the byte is discarded and an error pulse is raised. Every accepted write advances an internal address pointer, which wraps.

Top module: `cmd_data_router`

## Requirements
- R1: After reset, cmd_valid, mem_we and enc_err are low, and the write pointer is 0. The mode is divide-by-4 with encoding off.
- R2: rx_ack equals rx_valid while no byte is held. In the cycle after a byte is accepted, rx_ack stays low even if rx_valid is high.
- R3: A byte accepted with rx_is_cmd=1 gives exactly one cycle of cmd_valid, with cmd_byte equal to the byte, one clock after acceptance. No memory write occurs.
- R4: With encoding off, a data byte is written one clock after acceptance. mem_wdata holds the byte zero-extended, and mem_wide is 0.
- R5: With encoding on, a data byte whose bit 7 is 0 writes a 7-segment pattern, with mem_wide 0. The pattern is taken from bits 3..0 only. Its bits 6..0 are segments g,f,e,d,c,b,a. Inputs 0..9 give 3F,06,5B,4F,66,6D,7D,07,7F,6F. Inputs A..F give 40,08,63,50,73,00 (hex).
- R6: The 7-segment encoder works in both divide-by-3 and divide-by-4 mode.
- R7: With encoding on in divide-by-4 mode, a data byte whose bit 7 is 1 writes a 14-segment pattern of bits 6..0, with mem_wide 1. The segment bit positions are: a=0, b=1, c=2, d=3, e=4, f=5, left middle=6, right middle=7, upper-left diagonal=8, upper centre=9, upper-right diagonal=10, lower-left diagonal=11, lower centre=12, lower-right diagonal=13. Codes 00..09 are digits and 0A..23 are letters A..Z. Codes 24..30 are the symbols + - * / \ = _ ( ) [ ] | $. Examples: code 00 gives 0C3F, 0A gives 00F7, 23 gives 0C09, 25 gives 00C0, 30 gives 12ED.
- R8: 14-segment codes 31..7F give an all-zero pattern, which is still written.
- R9: A 14-segment request in divide-by-3 mode performs no write, leaves the pointer unchanged, and raises enc_err for exactly one cycle.
- R10: mem_addr carries the pointer value for each write. The pointer then advances by one, wrapping after 2^ADDR_W writes.
- R11: The mode bits load from cfg_div3 and cfg_segdec only in cycles where cfg_we is 1. At other times they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receiver offers a byte |
| rx_is_cmd | input | 1 | Offered byte is a command |
| rx_byte | input | 8 | Offered byte |
| rx_ack | output | 1 | Byte consumed this cycle |
| cfg_we | input | 1 | Load the mode bits |
| cfg_div3 | input | 1 | 1 = divide-by-3, 0 = divide-by-4 |
| cfg_segdec | input | 1 | 1 = character encoding on |
| cmd_valid | output | 1 | Command byte strobe |
| cmd_byte | output | 8 | Command byte |
| mem_we | output | 1 | Display memory write strobe |
| mem_wide | output | 1 | mem_wdata holds a 14-bit pattern |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | 14 | Write data |
| enc_err | output | 1 | 14-segment request refused |

## Verification
The bench drives bytes with each tag and checks the raw path. It sends nibbles from both halves of the 7-segment table, including a byte with junk in bits 6..4. This separates a correct nibble slice from a wider index. For 14-segment codes it covers a digit, the first and last letter, two symbols and undefined codes. The undefined codes show whether the table boundary sits in the right place. Both encoders are tried in each multiplex mode. A mode change is attempted without the load strobe. A run of writes long enough to wrap the pointer shows whether the error path and the write path each move the pointer as the requirements state.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
    localparam int BYTE_W  = 8;
    localparam int NIB_W   = 4;
    localparam int CODE_W  = 7;
    localparam int PAT7_W  = 7;
    localparam int PAT14_W = 14;

    localparam logic [PAT14_W-1:0] SA  = 14'h0001;
    localparam logic [PAT14_W-1:0] SB  = 14'h0002;
    localparam logic [PAT14_W-1:0] SC  = 14'h0004;
    localparam logic [PAT14_W-1:0] SD  = 14'h0008;
    localparam logic [PAT14_W-1:0] SE  = 14'h0010;
    localparam logic [PAT14_W-1:0] SF  = 14'h0020;
    localparam logic [PAT14_W-1:0] SG1 = 14'h0040;
    localparam logic [PAT14_W-1:0] SG2 = 14'h0080;
    localparam logic [PAT14_W-1:0] SH  = 14'h0100;
    localparam logic [PAT14_W-1:0] SI  = 14'h0200;
    localparam logic [PAT14_W-1:0] SJ  = 14'h0400;
    localparam logic [PAT14_W-1:0] SK  = 14'h0800;
    localparam logic [PAT14_W-1:0] SL  = 14'h1000;
    localparam logic [PAT14_W-1:0] SM  = 14'h2000;
endpackage

// File: rtl/seg7_enc.sv
module seg7_enc
    import cdr_pkg::*;
(
    input  logic [NIB_W-1:0]  nib,
    output logic [PAT7_W-1:0] pat
);
    always_comb begin
        case (nib)
            4'h0: pat = 7'h3F;
            4'h1: pat = 7'h06;
            4'h2: pat = 7'h5B;
            4'h3: pat = 7'h4F;
            4'h4: pat = 7'h66;
            4'h5: pat = 7'h6D;
            4'h6: pat = 7'h7D;
            4'h7: pat = 7'h07;
            4'h8: pat = 7'h7F;
            4'h9: pat = 7'h6F;
            4'hA: pat = 7'h40;
            4'hB: pat = 7'h08;
            4'hC: pat = 7'h63;
            4'hD: pat = 7'h50;
            4'hE: pat = 7'h73;
            default: pat = 7'h00;
        endcase
    end
endmodule

// File: rtl/seg14_enc.sv
module seg14_enc
    import cdr_pkg::*;
(
    input  logic [CODE_W-1:0]  code,
    output logic [PAT14_W-1:0] pat
);
    always_comb begin
        case (code)
            7'h00: pat = SA|SB|SC|SD|SE|SF|SJ|SK;
            7'h01: pat = SB|SC|SJ;
            7'h02: pat = SA|SB|SG1|SG2|SE|SD;
            7'h03: pat = SA|SB|SC|SD|SG2;
            7'h04: pat = SF|SG1|SG2|SB|SC;
            7'h05: pat = SA|SF|SG1|SG2|SC|SD;
            7'h06: pat = SA|SF|SE|SD|SC|SG1|SG2;
            7'h07: pat = SA|SB|SC;
            7'h08: pat = SA|SB|SC|SD|SE|SF|SG1|SG2;
            7'h09: pat = SA|SB|SC|SD|SF|SG1|SG2;
            7'h0A: pat = SA|SB|SC|SE|SF|SG1|SG2;
            7'h0B: pat = SA|SB|SC|SD|SG2|SI|SL;
            7'h0C: pat = SA|SD|SE|SF;
            7'h0D: pat = SA|SB|SC|SD|SI|SL;
            7'h0E: pat = SA|SD|SE|SF|SG1;
            7'h0F: pat = SA|SE|SF|SG1;
            7'h10: pat = SA|SC|SD|SE|SF|SG2;
            7'h11: pat = SB|SC|SE|SF|SG1|SG2;
            7'h12: pat = SA|SD|SI|SL;
            7'h13: pat = SB|SC|SD|SE;
            7'h14: pat = SE|SF|SG1|SJ|SM;
            7'h15: pat = SD|SE|SF;
            7'h16: pat = SB|SC|SE|SF|SH|SJ;
            7'h17: pat = SB|SC|SE|SF|SH|SM;
            7'h18: pat = SA|SB|SC|SD|SE|SF;
            7'h19: pat = SA|SB|SE|SF|SG1|SG2;
            7'h1A: pat = SA|SB|SC|SD|SE|SF|SM;
            7'h1B: pat = SA|SB|SE|SF|SG1|SG2|SM;
            7'h1C: pat = SA|SC|SD|SF|SG1|SG2;
            7'h1D: pat = SA|SI|SL;
            7'h1E: pat = SB|SC|SD|SE|SF;
            7'h1F: pat = SE|SF|SK|SJ;
            7'h20: pat = SB|SC|SE|SF|SK|SM;
            7'h21: pat = SH|SJ|SK|SM;
            7'h22: pat = SH|SJ|SL;
            7'h23: pat = SA|SD|SJ|SK;
            7'h24: pat = SG1|SG2|SI|SL;
            7'h25: pat = SG1|SG2;
            7'h26: pat = SG1|SG2|SH|SI|SJ|SK|SL|SM;
            7'h27: pat = SJ|SK;
            7'h28: pat = SH|SM;
            7'h29: pat = SG1|SG2|SD;
            7'h2A: pat = SD;
            7'h2B: pat = SJ|SM;
            7'h2C: pat = SH|SK;
            7'h2D: pat = SA|SD|SE|SF;
            7'h2E: pat = SA|SB|SC|SD;
            7'h2F: pat = SI|SL;
            7'h30: pat = SA|SC|SD|SF|SG1|SG2|SI|SL;
            default: pat = '0;
        endcase
    end
endmodule

// File: rtl/cmd_data_router.sv
module cmd_data_router
    import cdr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic                rx_is_cmd,
    input  logic [BYTE_W-1:0]   rx_byte,
    output logic                rx_ack,
    input  logic                cfg_we,
    input  logic                cfg_div3,
    input  logic                cfg_segdec,
    output logic                cmd_valid,
    output logic [BYTE_W-1:0]   cmd_byte,
    output logic                mem_we,
    output logic                mem_wide,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [PAT14_W-1:0]  mem_wdata,
    output logic                enc_err
);
    localparam int RAW_PAD = PAT14_W - BYTE_W;
    localparam int P7_PAD  = PAT14_W - PAT7_W;

    typedef struct packed {
        logic                hold_vld;
        logic [BYTE_W-1:0]   hold_byte;
        logic                hold_cmd;
        logic                div3;
        logic                segdec;
        logic [ADDR_W-1:0]   ptr;
        logic                cmd_valid;
        logic [BYTE_W-1:0]   cmd_byte;
        logic                mem_we;
        logic                mem_wide;
        logic [ADDR_W-1:0]   mem_addr;
        logic [PAT14_W-1:0]  mem_wdata;
        logic                err;
    } st_t;

    st_t st_d, st_q;
    logic [PAT7_W-1:0]  pat7;
    logic [PAT14_W-1:0] pat14;

    seg7_enc i_seg7 (
        .nib (st_q.hold_byte[NIB_W-1:0]),
        .pat (pat7)
    );

    seg14_enc i_seg14 (
        .code (st_q.hold_byte[CODE_W-1:0]),
        .pat  (pat14)
    );

    assign rx_ack = rx_valid && !st_q.hold_vld;

    always_comb begin
        st_d           = st_q;
        st_d.cmd_valid = 1'b0;
        st_d.mem_we    = 1'b0;
        st_d.err       = 1'b0;

        if (cfg_we) begin
            st_d.div3   = cfg_div3;
            st_d.segdec = cfg_segdec;
        end

        if (st_q.hold_vld) begin
            st_d.hold_vld = 1'b0;
            if (st_q.hold_cmd) begin
                st_d.cmd_valid = 1'b1;
                st_d.cmd_byte  = st_q.hold_byte;
            end else if (st_q.segdec && st_q.hold_byte[BYTE_W-1] && st_q.div3) begin
                st_d.err = 1'b1;
            end else begin
                st_d.mem_we   = 1'b1;
                st_d.mem_addr = st_q.ptr;
                st_d.ptr      = st_q.ptr + 1'b1;
                if (!st_q.segdec) begin
                    st_d.mem_wide  = 1'b0;
                    st_d.mem_wdata = {{RAW_PAD{1'b0}}, st_q.hold_byte};
                end else if (!st_q.hold_byte[BYTE_W-1]) begin
                    st_d.mem_wide  = 1'b0;
                    st_d.mem_wdata = {{P7_PAD{1'b0}}, pat7};
                end else begin
                    st_d.mem_wide  = 1'b1;
                    st_d.mem_wdata = pat14;
                end
            end
        end

        if (rx_ack) begin
            st_d.hold_vld  = 1'b1;
            st_d.hold_byte = rx_byte;
            st_d.hold_cmd  = rx_is_cmd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_valid = st_q.cmd_valid;
    assign cmd_byte  = st_q.cmd_byte;
    assign mem_we    = st_q.mem_we;
    assign mem_wide  = st_q.mem_wide;
    assign mem_addr  = st_q.mem_addr;
    assign mem_wdata = st_q.mem_wdata;
    assign enc_err   = st_q.err;

    // R2
    ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |=> !rx_ack);

    // R3
    cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R3
    cmd_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && mem_we));

    // R9
    err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_err |-> (!mem_we && $stable(st_q.ptr)));

    // R10
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (st_q.ptr == ADDR_W'(mem_addr + 1'b1)));

    // R7
    wide_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_wide) |-> $past(!st_q.div3));
endmodule

// File: tb/test_cmd_data_router.sv
module test_cmd_data_router;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_valid = 1'b0;
    logic              rx_is_cmd = 1'b0;
    logic [7:0]        rx_byte = '0;
    logic              rx_ack;
    logic              cfg_we = 1'b0;
    logic              cfg_div3 = 1'b0;
    logic              cfg_segdec = 1'b0;
    logic              cmd_valid;
    logic [7:0]        cmd_byte;
    logic              mem_we;
    logic              mem_wide;
    logic [ADDR_W-1:0] mem_addr;
    logic [13:0]       mem_wdata;
    logic              enc_err;

    int n_chk = 0;
    int n_bad = 0;
    int exp_ptr = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cmd_data_router #(.ADDR_W(ADDR_W)) i_cmd_data_router (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_is_cmd(rx_is_cmd),
        .rx_byte(rx_byte), .rx_ack(rx_ack), .cfg_we(cfg_we), .cfg_div3(cfg_div3),
        .cfg_segdec(cfg_segdec), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .enc_err(enc_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_mode(input bit div3, input bit segdec);
        @(negedge clk);
        cfg_we = 1'b1; cfg_div3 = div3; cfg_segdec = segdec;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Offers one byte, checks the handshake, returns the strobes seen one clock after acceptance
    task automatic send(input string req, input bit is_cmd, input logic [7:0] b,
                        output bit o_cmd, output logic [7:0] o_cb, output bit o_we,
                        output bit o_wide, output int o_addr, output int o_data, output bit o_err);
        @(negedge clk);
        rx_valid = 1'b1; rx_is_cmd = is_cmd; rx_byte = b;
        #0.1;
        chk("R2", "ack idle", int'(rx_ack), 1);
        @(posedge clk);
        @(negedge clk);
        chk("R2", "ack busy", int'(rx_ack), 0);
        rx_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        o_cmd = cmd_valid; o_cb = cmd_byte; o_we = mem_we; o_wide = mem_wide;
        o_addr = int'(mem_addr); o_data = int'(mem_wdata); o_err = enc_err;
        @(negedge clk);
        chk(req, "strobes one cycle", int'({cmd_valid, mem_we, enc_err}), 0);
    endtask

    task automatic send_write(input string req, input logic [7:0] b, input int exp_data, input bit exp_wide);
        bit c, we, wd, er; logic [7:0] cb; int ad, dt;
        send(req, 1'b0, b, c, cb, we, wd, ad, dt, er);
        chk(req, "mem_we", int'(we), 1);
        chk(req, "cmd_valid", int'(c), 0);
        chk(req, "enc_err", int'(er), 0);
        chk("R10", "mem_addr", ad, exp_ptr);
        chk(req, "mem_wdata", dt, exp_data);
        chk(req, "mem_wide", int'(wd), int'(exp_wide));
        exp_ptr = (exp_ptr + 1) % (1 << ADDR_W);
    endtask

    task automatic t_reset();
        chk("R1", "outputs after reset", int'({cmd_valid, mem_we, enc_err, rx_ack}), 0);
    endtask

    task automatic t_command();
        bit c, we, wd, er; logic [7:0] cb; int ad, dt;
        send("R3", 1'b1, 8'hA5, c, cb, we, wd, ad, dt, er);
        chk("R3", "cmd_valid", int'(c), 1);
        chk("R3", "cmd_byte", int'(cb), 8'hA5);
        chk("R3", "no write", int'(we), 0);
    endtask

    task automatic t_raw();
        send_write("R4", 8'h3C, 14'h003C, 1'b0);
        send_write("R4", 8'hF1, 14'h00F1, 1'b0);
    endtask

    task automatic t_seg7();
        set_mode(1'b0, 1'b1);
        send_write("R5", 8'h00, 14'h3F, 1'b0);
        send_write("R5", 8'h07, 14'h07, 1'b0);
        send_write("R5", 8'h09, 14'h6F, 1'b0);
        send_write("R5", 8'h0A, 14'h40, 1'b0);
        send_write("R5", 8'h0F, 14'h00, 1'b0);
        send_write("R5", 8'h75, 14'h6D, 1'b0);
    endtask

    task automatic t_seg7_div3();
        set_mode(1'b1, 1'b1);
        send_write("R6", 8'h02, 14'h5B, 1'b0);
        send_write("R6", 8'h0E, 14'h73, 1'b0);
    endtask

    task automatic t_seg14();
        set_mode(1'b0, 1'b1);
        send_write("R7", 8'h80, 14'h0C3F, 1'b1);
        send_write("R7", 8'h8A, 14'h00F7, 1'b1);
        send_write("R7", 8'hA3, 14'h0C09, 1'b1);
        send_write("R7", 8'hA5, 14'h00C0, 1'b1);
        send_write("R7", 8'hB0, 14'h12ED, 1'b1);
    endtask

    task automatic t_seg14_undef();
        send_write("R8", 8'hB1, 14'h0000, 1'b1);
        send_write("R8", 8'hFF, 14'h0000, 1'b1);
    endtask

    task automatic t_seg14_div3();
        bit c, we, wd, er; logic [7:0] cb; int ad, dt;
        set_mode(1'b1, 1'b1);
        send("R9", 1'b0, 8'h8A, c, cb, we, wd, ad, dt, er);
        chk("R9", "no write", int'(we), 0);
        chk("R9", "enc_err", int'(er), 1);
        send_write("R9", 8'h01, 14'h06, 1'b0);
    endtask

    task automatic t_cfg_hold();
        @(negedge clk);
        cfg_we = 1'b0; cfg_div3 = 1'b0; cfg_segdec = 1'b0;
        begin
            bit c, we, wd, er; logic [7:0] cb; int ad, dt;
            send("R11", 1'b0, 8'h8A, c, cb, we, wd, ad, dt, er);
            chk("R11", "mode held (div3 refuses)", int'({we, er}), 2'b01);
        end
        set_mode(1'b0, 1'b0);
        send_write("R11", 8'h8A, 14'h008A, 1'b0);
    endtask

    task automatic t_wrap();
        for (int k = 0; k < (1 << ADDR_W) + 2; k++)
            send_write("R10", 8'(k), k & 8'hFF, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_command();
        t_raw();
        t_seg7();
        t_seg7_div3();
        t_seg14();
        t_seg14_undef();
        t_seg14_div3();
        t_cfg_hold();
        t_wrap();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule